// File: doc/BRIEF.md
# Parallel Access-Map Prefetch Generator

This block turns one zone's access history into a short burst of prefetch line addresses. A request carries the 2-bit state of every cache line in a fixed-size zone, the position of the demand access inside that zone, and the line address where the zone starts. In a single cycle the block lines the map up around the demand position and tests every forward stride from 1 to `MAX_STRIDE` at once. Stride k is a candidate when the two lines k and 2k behind the demand position have already been touched and the line k ahead has never been touched.

The candidates found for one request are held as a bit vector. A priority encoder takes the smallest stride, an adder turns it into a line address, and once the consumer takes that address the chosen bit is cleared, so the next stride comes out on the following cycle. A new request always replaces whatever candidates are still pending. Sending the prefetches to memory and writing the map states back belong to other blocks.

Top module: `ampm_prefetch_gen`

## Requirements
- R1: Each zone line i has a 2-bit state in `req_map[2*i+1:2*i]`, coded 0 = untouched, 1 = demand-accessed, 2 = prefetched and not yet used, 3 = prefetched and then used.
- R2: For a stride k in 1..MAX_STRIDE, k is a candidate exactly when the line at offset-k and the line at offset-2k each hold code 1 or 3, and the line at offset+k holds code 0.
- R3: A stride whose line at offset+k lies at or beyond the end of the zone, or whose line at offset-2k would lie below line 0, is never a candidate.
- R4: Each emitted address equals `req_zone_base + req_offset + k` for the selected stride k, computed as a line address.
- R5: The candidates of one request are emitted one per accepted transfer, in strictly ascending stride order, smallest stride first, and each one exactly once.
- R6: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` holds its value.
- R7: A request accepted on a clock edge replaces all pending candidates. Its first address, if it has one, appears on `pf_valid`/`pf_addr` right after that edge.
- R8: `pf_valid` is low when a request finds no candidate, and it is low after the last candidate has been taken.
- R9: After reset, `pf_valid` is low until a request with at least one candidate arrives.
- R10: A line in code 2 (prefetched, unused) does not count as history for the offset-k or offset-2k positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A new zone map and demand position are present |
| req_map | input | 2*ZONE_LINES | Per-line 2-bit states of the zone, line 0 in the low bits |
| req_offset | input | $clog2(ZONE_LINES) | Line index of the demand access inside the zone |
| req_zone_base | input | ADDR_W | Line address of zone line 0 |
| pf_valid | output | 1 | A prefetch line address is offered |
| pf_ready | input | 1 | The consumer takes the offered address on this edge |
| pf_addr | output | ADDR_W | Prefetch line address |

## Verification
A corrupted candidate register shows up at the ports on the cycle after the request: a stride is missing from the burst, a stride appears that the map does not justify, or an address comes out twice. A broken feedback clear shows the same address offered again right after a completed transfer, and a bad priority pick shows as a burst that is out of order. These faults are visible within one transfer of their cause. So the bench checks every offered address, on every cycle, against the ordered list that it derives from the map itself, and it also checks that the stream is empty at the end of each burst.

// File: rtl/ampm_pkg.sv
package ampm_pkg;

    // Per-line history codes carried in the zone map
    typedef enum logic [1:0] {
        LN_INIT   = 2'd0,
        LN_ACCESS = 2'd1,
        LN_PREF   = 2'd2,
        LN_HIT    = 2'd3
    } line_st_e;

    // A line counts as demand history when it was accessed or a prefetch of it was used
    function automatic logic line_used(input logic [1:0] st);
        return (st == LN_ACCESS) || (st == LN_HIT);
    endfunction

endpackage

// File: rtl/ampm_map_align.sv
// Extracts a window of line states centred on the demand line:
// window slot i holds the line at relative position i - 2*MAX_STRIDE.
module ampm_map_align #(
    parameter int ZONE_LINES = 64,
    parameter int MAX_STRIDE = 16,
    parameter int OFF_W      = $clog2(ZONE_LINES),
    localparam int WIN       = 3 * MAX_STRIDE + 1
) (
    input  logic [2*ZONE_LINES-1:0] map_i,
    input  logic [OFF_W-1:0]        off_i,
    output logic [2*WIN-1:0]        win_st_o,
    output logic [WIN-1:0]          win_ok_o
);

    always_comb begin
        int  pos;
        int  idx;
        logic in_zone;
        win_st_o = '0;
        win_ok_o = '0;
        for (int i = 0; i < WIN; i++) begin
            pos     = int'(off_i) + i - 2 * MAX_STRIDE;
            in_zone = (pos >= 0) && (pos < ZONE_LINES);
            idx     = in_zone ? pos : 0;
            win_ok_o[i]        = in_zone;
            win_st_o[2*i +: 2] = in_zone ? map_i[2*idx +: 2] : 2'b00;
        end
    end

endmodule

// File: rtl/ampm_stride_match.sv
// Tests every forward stride against the aligned window in parallel.
module ampm_stride_match
    import ampm_pkg::*;
#(
    parameter int MAX_STRIDE = 16,
    localparam int WIN       = 3 * MAX_STRIDE + 1,
    localparam int CTR       = 2 * MAX_STRIDE
) (
    input  logic [2*WIN-1:0]      win_st_i,
    input  logic [WIN-1:0]        win_ok_i,
    output logic [MAX_STRIDE-1:0] cand_o
);

    for (genvar k = 1; k <= MAX_STRIDE; k++) begin : g_stride
        logic [1:0] ahead_st;
        logic [1:0] back1_st;
        logic [1:0] back2_st;
        assign ahead_st = win_st_i[2*(CTR+k)   +: 2];
        assign back1_st = win_st_i[2*(CTR-k)   +: 2];
        assign back2_st = win_st_i[2*(CTR-2*k) +: 2];
        assign cand_o[k-1] = win_ok_i[CTR+k]   && (ahead_st == LN_INIT)
                          && win_ok_i[CTR-k]   && line_used(back1_st)
                          && win_ok_i[CTR-2*k] && line_used(back2_st);
    end

endmodule

// File: rtl/ampm_cand_pick.sv
// Lowest-stride-first selection over the candidate vector.
module ampm_cand_pick #(
    parameter int MAX_STRIDE = 16,
    localparam int SW        = $clog2(MAX_STRIDE + 1)
) (
    input  logic [MAX_STRIDE-1:0] cand_i,
    output logic                  any_o,
    output logic [SW-1:0]         stride_o,
    output logic [MAX_STRIDE-1:0] onehot_o
);

    always_comb begin
        stride_o = '0;
        onehot_o = '0;
        for (int i = MAX_STRIDE - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                stride_o    = SW'(i + 1);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
        any_o = |cand_i;
    end

endmodule

// File: rtl/ampm_prefetch_gen.sv
module ampm_prefetch_gen #(
    parameter int ZONE_LINES = 64,
    parameter int MAX_STRIDE = 16,
    parameter int ADDR_W     = 32,
    localparam int OFF_W     = $clog2(ZONE_LINES),
    localparam int WIN       = 3 * MAX_STRIDE + 1,
    localparam int SW        = $clog2(MAX_STRIDE + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [2*ZONE_LINES-1:0] req_map,
    input  logic [OFF_W-1:0]        req_offset,
    input  logic [ADDR_W-1:0]       req_zone_base,
    output logic                    pf_valid,
    input  logic                    pf_ready,
    output logic [ADDR_W-1:0]       pf_addr
);

    typedef struct packed {
        logic [MAX_STRIDE-1:0] cand;
        logic [ADDR_W-1:0]     base;
    } gen_st_t;

    gen_st_t gen_d, gen_q;

    logic [2*WIN-1:0]      win_st;
    logic [WIN-1:0]        win_ok;
    logic [MAX_STRIDE-1:0] match_vec;
    logic                  cand_any;
    logic [SW-1:0]         cand_stride;
    logic [MAX_STRIDE-1:0] cand_onehot;

    ampm_map_align #(
        .ZONE_LINES (ZONE_LINES),
        .MAX_STRIDE (MAX_STRIDE),
        .OFF_W      (OFF_W)
    ) align_i (
        .map_i    (req_map),
        .off_i    (req_offset),
        .win_st_o (win_st),
        .win_ok_o (win_ok)
    );

    ampm_stride_match #(
        .MAX_STRIDE (MAX_STRIDE)
    ) match_i (
        .win_st_i (win_st),
        .win_ok_i (win_ok),
        .cand_o   (match_vec)
    );

    ampm_cand_pick #(
        .MAX_STRIDE (MAX_STRIDE)
    ) pick_i (
        .cand_i   (gen_q.cand),
        .any_o    (cand_any),
        .stride_o (cand_stride),
        .onehot_o (cand_onehot)
    );

    assign pf_valid = cand_any;
    assign pf_addr  = gen_q.base + ADDR_W'(cand_stride);

    always_comb begin
        gen_d = gen_q;
        if (req_valid) begin
            // a fresh request overwrites whatever is still pending
            gen_d.cand = match_vec;
            gen_d.base = req_zone_base + ADDR_W'(req_offset);
        end else if (pf_valid && pf_ready) begin
            // feedback: retire the stride just handed out
            gen_d.cand = gen_q.cand & ~cand_onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_q <= '0;
        end else begin
            gen_q <= gen_d;
        end
    end

endmodule

// File: rtl/ampm_prefetch_gen_chk.sv
module ampm_prefetch_gen_chk #(
    parameter int MAX_STRIDE = 16,
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [OFF_W-1:0]  req_offset,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);

    logic [ADDR_W-1:0] prev_addr;
    logic [ADDR_W-1:0] addr_step;

    always_ff @(posedge clk) begin
        prev_addr <= pf_addr;
    end
    assign addr_step = pf_addr - prev_addr;

    // R6: a stalled offer is held unchanged
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready && !req_valid) |=> (pf_valid && $stable(pf_addr)));

    // R5: after a transfer the next offer is a strictly larger stride of the same burst
    a_r5_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !req_valid) |=>
            (!pf_valid || (addr_step != '0 && addr_step < ADDR_W'(MAX_STRIDE))));

    // R8: an empty stream stays empty without a new request
    a_r8_stay_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!pf_valid && !req_valid) |=> !pf_valid);

    // R3: a demand at line 0 or 1 has no room for two lines of history
    a_r3_low_offset_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_offset < OFF_W'(2)) |=> !pf_valid);

    // R9: nothing is offered on the first cycle out of reset
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !pf_valid);

endmodule

bind ampm_prefetch_gen ampm_prefetch_gen_chk #(
    .MAX_STRIDE (MAX_STRIDE),
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr)
);

// File: tb/ampm_prefetch_gen_tb_top.sv
`timescale 1ns/1ps
module ampm_prefetch_gen_tb_top;

    localparam int LINES = 64;
    localparam int S     = 16;
    localparam int AW    = 32;
    localparam int OW    = $clog2(LINES);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic [2*LINES-1:0] req_map = '0;
    logic [OW-1:0]   req_offset = '0;
    logic [AW-1:0]   req_zone_base = '0;
    logic            pf_valid;
    logic            pf_ready = 1'b0;
    logic [AW-1:0]   pf_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    ampm_prefetch_gen #(
        .ZONE_LINES (LINES),
        .MAX_STRIDE (S),
        .ADDR_W     (AW)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_map       (req_map),
        .req_offset    (req_offset),
        .req_zone_base (req_zone_base),
        .pf_valid      (pf_valid),
        .pf_ready      (pf_ready),
        .pf_addr       (pf_addr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected candidates from the R2/R3/R10 rule
    function automatic logic [S-1:0] expect_cand(input logic [2*LINES-1:0] m, input int off);
        logic [S-1:0] c;
        c = '0;
        for (int k = 1; k <= S; k++) begin
            if (off + k < LINES && off - 2*k >= 0) begin
                logic [1:0] a, b, f;
                a = m[2*(off-k) +: 2];
                b = m[2*(off-2*k) +: 2];
                f = m[2*(off+k) +: 2];
                c[k-1] = (a == 2'd1 || a == 2'd3) && (b == 2'd1 || b == 2'd3) && (f == 2'd0);
            end
        end
        return c;
    endfunction

    function automatic logic [2*LINES-1:0] set_line(input logic [2*LINES-1:0] m, input int i,
                                                    input logic [1:0] st);
        logic [2*LINES-1:0] r;
        r = m;
        r[2*i +: 2] = st;
        return r;
    endfunction

    // Present one request for one edge; called on a falling edge
    task automatic send(input logic [2*LINES-1:0] m, input int off, input logic [AW-1:0] zb);
        req_map       = m;
        req_offset    = OW'(off);
        req_zone_base = zb;
        req_valid     = 1'b1;
        pf_ready      = 1'b0;
        @(negedge clk);
        req_valid     = 1'b0;
    endtask

    // Take up to 'limit' addresses with random back-pressure, checking each offered cycle
    task automatic drain(input logic [S-1:0] c, input logic [AW-1:0] base,
                         input int limit, input string req);
        int taken = 0;
        for (int k = 1; k <= S; k++) begin
            if (c[k-1] && taken < limit) begin
                int guard = 0;
                forever begin
                    chk(pf_valid === 1'b1, req, "valid with pending stride", AW'(pf_valid), 1);
                    chk(pf_addr === base + AW'(k), req, "prefetch address", pf_addr, base + AW'(k));
                    pf_ready = ($urandom_range(0, 3) != 0) || (guard > 6);
                    guard++;
                    @(negedge clk);
                    if (pf_ready) break;
                end
                pf_ready = 1'b0;
                taken++;
            end
        end
        if (limit > S) begin
            chk(pf_valid === 1'b0, "R8", "empty after burst", AW'(pf_valid), 0);
        end
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [2*LINES-1:0] m;
        logic [S-1:0]       c;
        logic [AW-1:0]      zb;
        void'($urandom(32'd1398));

        repeat (3) @(negedge clk);
        chk(pf_valid === 1'b0, "R9", "valid in reset", AW'(pf_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pf_valid === 1'b0, "R9", "valid after reset", AW'(pf_valid), 0);

        // R2/R4: unit stride history at lines 8,9, demand at 10 -> only line 11
        zb = 32'h0001_0000;
        m = '0;
        m = set_line(m, 8, 2'd1);
        m = set_line(m, 9, 2'd1);
        send(m, 10, zb);
        drain(16'h0001, zb + 32'd10, 99, "R2 R4 unit stride");

        // R10: prefetched-but-unused history does not count
        m = '0;
        m = set_line(m, 8, 2'd2);
        m = set_line(m, 9, 2'd2);
        send(m, 10, zb);
        chk(pf_valid === 1'b0, "R10", "prefetch-state history", AW'(pf_valid), 0);

        // R1: used-prefetch code 3 counts as history
        m = '0;
        m = set_line(m, 8, 2'd3);
        m = set_line(m, 9, 2'd3);
        send(m, 10, zb);
        drain(16'h0001, zb + 32'd10, 99, "R1 used prefetch code");

        // R2: target line already touched blocks the stride
        m = '0;
        m = set_line(m, 8, 2'd1);
        m = set_line(m, 9, 2'd1);
        m = set_line(m, 11, 2'd1);
        send(m, 10, zb);
        chk(pf_valid === 1'b0, "R2", "target not untouched", AW'(pf_valid), 0);

        // R3: demand at line 1 has no room below
        m = '1;
        m = set_line(m, 0, 2'd1);
        send(m, 1, zb);
        chk(pf_valid === 1'b0, "R3", "offset 1", AW'(pf_valid), 0);

        // R3: demand at line 62, all lower lines accessed -> only stride 1 fits
        m = '0;
        for (int i = 0; i < 62; i++) m = set_line(m, i, 2'd1);
        send(m, 62, zb);
        drain(16'h0001, zb + 32'd62, 99, "R3 zone top");

        // R5: dense history below line 40 -> all 16 strides, ascending
        m = '0;
        for (int i = 0; i < 40; i++) m = set_line(m, i, 2'd1);
        send(m, 40, zb);
        drain(16'hFFFF, zb + 32'd40, 99, "R5 R6 full burst");

        // R7: overwrite mid-burst
        send(m, 40, zb);
        drain(16'hFFFF, zb + 32'd40, 3, "R7 first burst");
        m = '0;
        m = set_line(m, 14, 2'd1);
        m = set_line(m, 17, 2'd1);
        send(m, 20, 32'h0002_0000);
        drain(16'h0004, 32'h0002_0014, 99, "R7 replaced burst");

        // Random zones with planted strides
        for (int it = 0; it < 60; it++) begin
            int s, off;
            m = '0;
            for (int i = 0; i < LINES; i++)
                if ($urandom_range(0, 7) == 0) m = set_line(m, i, 2'($urandom_range(1, 3)));
            s   = $urandom_range(1, 8);
            off = $urandom_range(0, LINES - 1);
            for (int j = 1; j <= 4; j++)
                if (off - s*j >= 0) m = set_line(m, off - s*j, ($urandom_range(0, 1) != 0) ? 2'd1 : 2'd3);
            zb = {$urandom_range(0, 32'hFFFF), 6'd0};
            c  = expect_cand(m, off);
            send(m, off, zb);
            if (c == '0) chk(pf_valid === 1'b0, "R8", "no candidate", AW'(pf_valid), 0);
            else         drain(c, zb + AW'(off), 99, "R2 R5 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule